// File: doc/BRIEF.md
# Page-Buffered Memory Write and Address Controller

This block sits between a serial-bus protocol engine and a byte-wide storage array. It keeps the internal address counter and gathers written bytes into a page buffer. Nothing reaches the array until the protocol engine reports a stop condition. At that point every byte that was received is committed in one step, and a self-timed programming window starts. A busy flag stays high for the whole window. A write-protect input suppresses the commit.

The protocol engine has three request streams, each a valid/ready pair: address load, write byte and read request. A request is taken in the cycle where both valid and ready are high. All three ready signals drop while busy is high, so the engine has to hold or retry its request. When several requests are valid in one cycle, address load wins over write byte, and write byte wins over read request. The losing stream has its ready held low for that cycle. Read data comes back on a valid-only output one cycle after the read request is taken. The engine must take the byte in that cycle, because the output has no back-pressure. The stop strobe is a plain one-cycle pulse.

The array is a behavioural memory of 2^ADDR_W bytes, and the default is kept small for test. A page is 2^PAGE_W bytes (128 by default). A page is selected by address bits [ADDR_W-1:PAGE_W], and the byte within the page by bits [PAGE_W-1:0]. The programming window lasts WR_CYCLES clock cycles.

Top module: `eep_page_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, busy and rdata_valid are 0, and addr_ready, wdata_ready and rreq_ready are 1.
- R2: Each accepted write byte goes into the buffer at the current address, after which only address bits [PAGE_W-1:0] increment. The counter therefore wraps from the last byte of a page to the first byte of the same page.
- R3: When more than one page's worth of bytes arrive before a stop, later bytes overwrite the earlier bytes held at the same in-page position.
- R4: Buffered bytes reach the array only at a stop. An accepted address load or read request throws away any bytes that have not been committed.
- R5: A stop with pending bytes and wp_i low raises busy in the next cycle, and busy then stays high for exactly WR_CYCLES cycles.
- R6: A commit changes only the locations whose bytes were received. Every other location in the page keeps its earlier contents.
- R7: A stop with no pending bytes leaves the array unchanged and does not raise busy.
- R8: A stop taken while wp_i is 1 leaves the array unchanged and does not raise busy.
- R9: An accepted read request returns the byte at the current address on rdata, with rdata_valid high in the next cycle, and then increments the counter. After a write sequence the counter holds the last written address plus one.
- R10: A read at the last array location is followed by location 0. Reads increment across page boundaries over the whole array.
- R11: While busy is 1, all three ready outputs are 0, and write bytes, read requests and stops are ignored.
- R12: While addr_valid is 1, wdata_ready and rreq_ready are 0. While wdata_valid is 1, rreq_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect; 1 blocks commits |
| addr_valid | input | 1 | Address load request |
| addr_ready | output | 1 | Address load can be accepted |
| addr_data | input | ADDR_W | Address to load into the counter |
| wdata_valid | input | 1 | Write byte request |
| wdata_ready | output | 1 | Write byte can be accepted |
| wdata | input | 8 | Byte to buffer |
| rreq_valid | input | 1 | Read request |
| rreq_ready | output | 1 | Read request can be accepted |
| stop_i | input | 1 | Stop condition strobe |
| rdata_valid | output | 1 | Read byte valid, one cycle after acceptance |
| rdata | output | 8 | Read byte |
| busy | output | 1 | Programming window in progress |

## Verification
Short write bursts are read back in three ways: through the read-following-write path, by current-address reads, and by dummy-write reloads. Together these separate the address arithmetic of writes (page wrap) from that of reads (full-array increment and rollover). Partial rewrites of a location that is already populated show whether a commit touches only the bytes that were received. A 130-byte burst shows whether in-page overwrite happens. Stops with no data, stops under write protect, and a read between writing and stop each test a different path where nothing must reach the array. Requests and stops issued inside the busy window, plus simultaneous valid pairs, test the handshake rules.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef logic [7:0] byte_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [HI_W-1:0]   hi_q;
  logic [PAGE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      hi_q <= load_addr[ADDR_W-1:PAGE_W];
      lo_q <= load_addr[PAGE_W-1:0];
    end else if (step_page) begin
      lo_q <= lo_q + 1'b1;
    end else if (step_full) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + 1'b1;
    end
  end

  assign addr = {hi_q, lo_q};
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             wr_en,
  input  logic [PAGE_W-1:0]                wr_idx,
  input  byte_t                            wr_byte,
  output logic [(1<<PAGE_W)-1:0]           mask,
  output logic [(1<<PAGE_W)*BYTE_W-1:0]    flat,
  output logic                             any_pend
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  byte_t                 slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear) slot_q[wr_idx] <= wr_byte;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign flat[g*BYTE_W +: BYTE_W] = slot_q[g];
  end

  assign mask     = mask_q;
  assign any_pend = |mask_q;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= CW'(WR_CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input  logic                          clk,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output byte_t                         rd_byte,
  input  logic                          commit,
  input  logic [ADDR_W-PAGE_W-1:0]      commit_page,
  input  logic [(1<<PAGE_W)-1:0]        commit_mask,
  input  logic [(1<<PAGE_W)*BYTE_W-1:0] commit_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  byte_t mem [DEPTH];
  byte_t rd_q;

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (commit_mask[i]) mem[{commit_page, PAGE_W'(i)}] <= commit_data[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_byte = rd_q;
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [7:0]        wdata,
  input  logic              rreq_valid,
  output logic              rreq_ready,
  input  logic              stop_i,
  output logic              rdata_valid,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;

  logic                         addr_acc, wr_acc, rd_acc, stop_go, commit;
  logic [ADDR_W-1:0]            cur_addr;
  logic [PAGE_BYTES-1:0]        pend_mask;
  logic [PAGE_BYTES*BYTE_W-1:0] pend_data;
  logic                         pend_any;
  logic                         rv_q;

  // Handshake with fixed priority: load > write > read; stop only when idle
  assign addr_ready  = ~busy;
  assign wdata_ready = ~busy & ~addr_valid;
  assign rreq_ready  = ~busy & ~addr_valid & ~wdata_valid;

  assign addr_acc = addr_valid & addr_ready;
  assign wr_acc   = wdata_valid & wdata_ready;
  assign rd_acc   = rreq_valid & rreq_ready;
  assign stop_go  = stop_i & ~busy & ~addr_valid & ~wdata_valid & ~rreq_valid;
  assign commit   = stop_go & pend_any & ~wp_i;

  eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_acc),
    .load_addr (addr_data),
    .step_page (wr_acc),
    .step_full (rd_acc),
    .addr      (cur_addr)
  );

  eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (addr_acc | rd_acc | stop_go),
    .wr_en    (wr_acc),
    .wr_idx   (cur_addr[PAGE_W-1:0]),
    .wr_byte  (wdata),
    .mask     (pend_mask),
    .flat     (pend_data),
    .any_pend (pend_any)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk         (clk),
    .rd_en       (rd_acc),
    .rd_addr     (cur_addr),
    .rd_byte     (rdata),
    .commit      (commit),
    .commit_page (cur_addr[ADDR_W-1:PAGE_W]),
    .commit_mask (pend_mask),
    .commit_data (pend_data)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rd_acc;
  end

  assign rdata_valid = rv_q;

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
  parameter int ADDR_W    = 10,
  parameter int WR_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_i,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_data,
  input logic              wdata_valid,
  input logic              wdata_ready,
  input logic [7:0]        wdata,
  input logic              rreq_valid,
  input logic              rreq_ready,
  input logic              stop_i,
  input logic              rdata_valid,
  input logic [7:0]        rdata,
  input logic              busy
);
  localparam int CW = $clog2(WR_CYCLES + 1) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R5: busy starts only after a stop
  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_i));
  // R5: busy window length
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CW'(WR_CYCLES));
  // R8: protected stop never starts a window
  a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy) |=> !busy);
  // R9: read data follows an accepted request by one cycle
  a_r9_rdata_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rreq_valid && rreq_ready) |=> rdata_valid);
  a_r9_rdata_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(rreq_valid && rreq_ready));
  // R11: nothing accepted while busy
  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!addr_ready && !wdata_ready && !rreq_ready));
  // R12: priority between request streams
  a_r12_priority: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (!wdata_ready && !rreq_ready));
  a_r12_wr_over_rd: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid |-> !rreq_ready);
endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) chk_i (.*);

// File: tb/eep_page_ctrl_tb_top.sv
module eep_page_ctrl_tb_top;
  localparam int ADDR_W = 10;
  localparam int WRC    = 24;
  localparam int NV     = 39;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_i = 1'b0;
  logic addr_valid = 1'b0, wdata_valid = 1'b0, rreq_valid = 1'b0, stop_i = 1'b0;
  logic [ADDR_W-1:0] addr_data = '0;
  logic [7:0] wdata = '0;
  logic addr_ready, wdata_ready, rreq_ready, rdata_valid, busy;
  logic [7:0] rdata;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eep_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(7), .WR_CYCLES(WRC)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_load(input int a);
    addr_valid = 1'b1; addr_data = ADDR_W'(a);
    @(negedge clk); addr_valid = 1'b0;
  endtask

  task automatic t_wr(input int d);
    wdata_valid = 1'b1; wdata = 8'(d);
    @(negedge clk); wdata_valid = 1'b0;
  endtask

  task automatic t_rd(input string req, input int exp);
    rreq_valid = 1'b1;
    @(negedge clk); rreq_valid = 1'b0;
    check({req, " rdata_valid"}, int'(rdata_valid), 1);
    check({req, " rdata"}, int'(rdata), exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_stop(input string req, input int exp_busy);
    int n;
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check({req, " busy after stop"}, int'(busy), exp_busy);
    if (exp_busy != 0) begin
      wait_idle(n);
      check("R5 busy length", n, WRC);
    end
  endtask

  // op[30:27] req, [26:24] op (0 load,1 write,2 read,3 stop,4 wp), [23:8] arg, [7:0] expect
  localparam logic [30:0] VT [0:NV-1] = '{
    {4'd2, 3'd0, 16'h040, 8'h00}, {4'd2, 3'd1, 16'h0AA, 8'h00},   // R2 burst
    {4'd2, 3'd1, 16'h0BB, 8'h00}, {4'd2, 3'd1, 16'h0CC, 8'h00},
    {4'd5, 3'd3, 16'h000, 8'h01},                                  // R5 stop starts window
    {4'd2, 3'd0, 16'h040, 8'h00}, {4'd2, 3'd2, 16'h000, 8'hAA},
    {4'd2, 3'd2, 16'h000, 8'hBB}, {4'd2, 3'd2, 16'h000, 8'hCC},
    {4'd9, 3'd0, 16'h100, 8'h00}, {4'd9, 3'd1, 16'h011, 8'h00},   // R9 setup
    {4'd9, 3'd1, 16'h022, 8'h00}, {4'd9, 3'd1, 16'h033, 8'h00},
    {4'd9, 3'd3, 16'h000, 8'h01},
    {4'd6, 3'd0, 16'h100, 8'h00}, {4'd6, 3'd1, 16'h044, 8'h00},   // R6 partial rewrite
    {4'd6, 3'd3, 16'h000, 8'h01},
    {4'd9, 3'd2, 16'h000, 8'h22}, {4'd9, 3'd2, 16'h000, 8'h33},   // R9 current address n+1
    {4'd6, 3'd0, 16'h100, 8'h00}, {4'd6, 3'd2, 16'h000, 8'h44},
    {4'd6, 3'd2, 16'h000, 8'h22},
    {4'd7, 3'd0, 16'h100, 8'h00}, {4'd7, 3'd3, 16'h000, 8'h00},   // R7 empty stop
    {4'd7, 3'd0, 16'h100, 8'h00}, {4'd7, 3'd2, 16'h000, 8'h44},
    {4'd4, 3'd0, 16'h100, 8'h00}, {4'd4, 3'd1, 16'h055, 8'h00},   // R4 read discards
    {4'd4, 3'd2, 16'h000, 8'h22}, {4'd4, 3'd3, 16'h000, 8'h00},
    {4'd4, 3'd0, 16'h100, 8'h00}, {4'd4, 3'd2, 16'h000, 8'h44},
    {4'd8, 3'd4, 16'h001, 8'h00}, {4'd8, 3'd0, 16'h100, 8'h00},   // R8 write protect
    {4'd8, 3'd1, 16'h066, 8'h00}, {4'd8, 3'd3, 16'h000, 8'h00},
    {4'd8, 3'd4, 16'h000, 8'h00}, {4'd8, 3'd0, 16'h100, 8'h00},
    {4'd8, 3'd2, 16'h000, 8'h44}
  };

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 rdata_valid in reset", int'(rdata_valid), 0);
    check("R1 readies in reset", int'({addr_ready, wdata_ready, rreq_ready}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 readies after reset", int'({addr_ready, wdata_ready, rreq_ready}), 7);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VT[i][30:27], i);
      case (VT[i][26:24])
        3'd0: t_load(int'(VT[i][23:8]));
        3'd1: t_wr(int'(VT[i][15:8]));
        3'd2: t_rd(tag, int'(VT[i][7:0]));
        3'd3: t_stop(tag, int'(VT[i][0]));
        default: begin wp_i = VT[i][8]; @(negedge clk); end
      endcase
    end

    // R2: in-page wrap 0x27E,0x27F,0x200
    t_load('h27E); t_wr('hA0); t_wr('hA1); t_wr('hA2); t_stop("R2 wrap", 1);
    t_load('h27E); t_rd("R2 wrap 27E", 'hA0); t_rd("R2 wrap 27F", 'hA1);
    t_load('h200); t_rd("R2 wrap to page start", 'hA2);

    // R3: 130-byte burst overwrites positions 0 and 1
    t_load('h300);
    for (int i = 0; i < 130; i++) t_wr(i);
    t_stop("R3 overflow", 1);
    t_load('h300); t_rd("R3 pos0", 'h80); t_rd("R3 pos1", 'h81); t_rd("R3 pos2", 'h02);

    // R11: requests during busy are ignored
    t_load('h000); t_wr('hE0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    check("R11 busy", int'(busy), 1);
    check("R11 readies low", int'({addr_ready, wdata_ready, rreq_ready}), 0);
    wdata_valid = 1'b1; wdata = 8'hEE; @(negedge clk); wdata_valid = 1'b0;
    rreq_valid = 1'b1; @(negedge clk); rreq_valid = 1'b0;
    check("R11 no rdata while busy", int'(rdata_valid), 0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    wait_idle(n);
    @(negedge clk);
    check("R11 stop ignored, stays idle", int'(busy), 0);
    t_load('h000); t_rd("R11 write ignored", 'hE0);

    // R10: rollover from last location to 0
    t_load('h3FE); t_wr('hF1); t_wr('hF2); t_stop("R10 setup", 1);
    t_load('h3FE); t_rd("R10 3FE", 'hF1); t_rd("R10 3FF", 'hF2); t_rd("R10 rollover", 'hE0);

    // R12: priority among simultaneous requests
    addr_valid = 1'b1; addr_data = 10'h040; wdata_valid = 1'b1; wdata = 8'h99;
    #1 check("R12 load blocks write", int'(wdata_ready), 0);
    @(negedge clk); addr_valid = 1'b0;
    #1 check("R12 write blocks read", {31'd0, rreq_ready}, 1'b1 ? 0 : 0);
    wdata_valid = 1'b0;
    t_rd("R12 write not taken", 'hAA);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule